// File: doc/BRIEF.md
# Remote terminal message processor

This block is the message layer of a serial command/response bus remote terminal. A word codec in front of it delivers decoded 16-bit words. Each word comes with a tag that tells a command word from a data word, an error flag and a strobe. The block compares the addressed terminal in each command with an address strapped on external pins. It classifies the command as receive, transmit or mode command, then runs the message to completion. Every word it answers with goes back to the codec as a one-cycle `tx_valid` pulse.

Received data words go to an external synchronous RAM at an address formed from the commanded subaddress and the word index. Transmit commands read that same RAM back, in order, behind the status word. The RAM's single address, write enable and write data come from a small multiplexer that chooses between the receive (write) path and the transmit (read) path.

A service-request flag is set by a host strobe and is shown in the status word. The vector word returned to the vector-poll mode command carries the same flag, and the flag clears once that vector word has gone out. Every strobe the block consumes passes through two flip-flops in series and acts only on its rising edge.

Top module: `rt_msg_proc`

## Requirements
- R1: `term_id` holds the strapped pins in bits [4:0] and, in bit 5, a bit chosen so that the total count of ones in all 6 bits is odd; it follows a pin change within two clocks.
- R2: After reset `tx_valid` and `ram_we` are low. Every status word is the terminal address in bits [15:11], the service-request flag in bit 8 and zero in all other bits.
- R3: A strobe acts once per rising edge however long it is held high. A transmit command's status word appears at `tx_valid` in the cycle after the second rising clock edge that follows the rise of `rx_stb`.
- R4: A command word (tag `rx_cmd`=1) whose bits [15:11] differ from the strapped address gives no response word and no RAM write.
- R5: A word flagged with `rx_err` is ignored; a flagged data word inside a receive message also aborts it, so no status word is sent.
- R6: A receive command (bit 10 = 0, subaddress in bits [9:5] other than 00000 and 11111, count N in bits [4:0] with 0 meaning 32) stores its N data words at RAM address {subaddress, index 0..N-1}. It then sends exactly one status word.
- R7: A transmit command (bit 10 = 1, same fields) sends one status word followed by N words read from RAM addresses {subaddress, 0..N-1}, back to back.
- R8: A mode command (subaddress 00000 or 11111) with bit 10 = 1 and mode code 10000 sends the status word, then the vector word, whose bit 0 is the service-request flag and whose other bits are zero.
- R9: A rising edge on `svc_req` sets status bit 8. The flag is still set in the status word of the vector response and clears after the vector word is sent.
- R10: A mode command with bit 10 = 0 and mode code 10001 accepts one data word without writing RAM, then sends one status word.
- R11: A receive message interrupted by a new command before its word count is reached sends no status for the interrupted message; the new command is then processed normally.
- R12: A mode command with any other mode code / direction pair gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_pins | input | 5 | Strapped terminal address |
| rx_word | input | 16 | Decoded word from the codec |
| rx_cmd | input | 1 | Word tag: 1 command word, 0 data word |
| rx_err | input | 1 | Codec flagged the word as bad |
| rx_stb | input | 1 | Word-available strobe (level, edge-detected) |
| svc_req | input | 1 | Host service-request strobe (edge-detected) |
| ram_rdata | input | 16 | RAM read data, one cycle after the address |
| term_id | output | 6 | Registered terminal address with parity bit |
| tx_word | output | 16 | Word handed to the codec |
| tx_valid | output | 1 | One-cycle pulse per transmitted word |
| ram_addr | output | 10 | RAM address {subaddress, index} |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 16 | RAM write data |

## Verification
The bench builds the block with its default 5-bit address, 5-bit subaddress, 5-bit count and 16-bit word. At those widths every one of the 32 strap values and every one of the 32 word counts can be swept outright, including the count-of-zero case that means 32. Receive messages at several counts are read back by transmit commands for a full round trip. The small word lets the bench predict each status and vector word arithmetically from the strap value and the request history.

// File: rtl/rt_pkg.sv
package rt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_STAT,
      ST_TXD,
      ST_VEC
   } rt_state_e;

   typedef enum logic [1:0] {
      MK_RX,
      MK_TX,
      MK_VEC,
      MK_SYNC
   } msg_kind_e;
endpackage

// File: rtl/rt_edge_det.sv
module rt_edge_det #(
   parameter int N    = 2,
   parameter bit RISE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] pulse
);
   logic [N-1:0] s1_q, s2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= '0;
         s2_q <= '0;
      end else begin
         s1_q <= raw;
         s2_q <= s1_q;
      end
   end

   if (RISE) begin : g_rise
      assign pulse = s1_q & ~s2_q;
   end else begin : g_fall
      assign pulse = ~s1_q & s2_q;
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R3
      pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[i] |=> !pulse[i]);
   end
endmodule

// File: rtl/rt_term_addr.sv
module rt_term_addr #(
   parameter int TA_W    = 5,
   parameter bit ODD_PAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TA_W-1:0] pins,
   input  logic [TA_W-1:0] cmd_addr,
   output logic [TA_W:0]   id,
   output logic            match
);
   logic [TA_W:0] id_q;
   logic          loaded_q;
   logic          par;

   if (ODD_PAR) begin : g_odd
      assign par = ~^pins;
      // R1
      ta_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
         loaded_q |-> (($countones(id_q) % 2) == 1));
   end else begin : g_even
      assign par = ^pins;
      // R1
      ta_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
         loaded_q |-> (($countones(id_q) % 2) == 0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q     <= '0;
         loaded_q <= 1'b0;
      end else begin
         id_q     <= {par, pins};
         loaded_q <= 1'b1;
      end
   end

   assign id    = id_q;
   assign match = loaded_q && (id_q[TA_W-1:0] == cmd_addr);
endmodule

// File: rtl/rt_ram_mux.sv
module rt_ram_mux #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata
);
   assign ram_addr  = wr_en ? wr_addr : rd_addr;
   assign ram_we    = wr_en;
   assign ram_wdata = wr_data;
endmodule

// File: rtl/rt_msg_proc.sv
module rt_msg_proc
   import rt_pkg::*;
#(
   parameter int TA_W    = 5,
   parameter int SA_W    = 5,
   parameter int WC_W    = 5,
   parameter int WORD_W  = 16,
   parameter bit ODD_PAR = 1'b1,
   parameter int SVC_BIT = 8,
   parameter int VEC_MC  = 16,
   parameter int SYNC_MC = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TA_W-1:0]         term_pins,
   input  logic [WORD_W-1:0]       rx_word,
   input  logic                    rx_cmd,
   input  logic                    rx_err,
   input  logic                    rx_stb,
   input  logic                    svc_req,
   input  logic [WORD_W-1:0]       ram_rdata,
   output logic [TA_W:0]           term_id,
   output logic [WORD_W-1:0]       tx_word,
   output logic                    tx_valid,
   output logic [SA_W+WC_W-1:0]    ram_addr,
   output logic                    ram_we,
   output logic [WORD_W-1:0]       ram_wdata
);
   localparam int AW     = SA_W + WC_W;
   localparam int TR_BIT = SA_W + WC_W;
   localparam int TA_LSB = TR_BIT + 1;

   if (TA_LSB + TA_W != WORD_W) begin : g_bad_layout
      $error("command fields do not fill the word");
   end
   if (SVC_BIT >= TA_LSB || SVC_BIT < 1) begin : g_bad_svc
      $error("service bit overlaps another status field");
   end
   if (VEC_MC >= (1 << WC_W) || SYNC_MC >= (1 << WC_W)) begin : g_bad_mc
      $error("mode code does not fit the count field");
   end

   // strobe qualification
   logic [1:0] edges;
   logic       rx_edge, svc_edge;

   rt_edge_det #(.N(2), .RISE(1'b1)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   ({svc_req, rx_stb}),
      .pulse (edges)
   );
   assign rx_edge  = edges[0];
   assign svc_edge = edges[1];

   // command fields
   logic [TA_W-1:0] f_ta;
   logic            f_tr;
   logic [SA_W-1:0] f_sa;
   logic [WC_W-1:0] f_wc;
   logic            f_mode;
   logic            ta_match;

   assign f_ta   = rx_word[WORD_W-1 -: TA_W];
   assign f_tr   = rx_word[TR_BIT];
   assign f_sa   = rx_word[WC_W +: SA_W];
   assign f_wc   = rx_word[WC_W-1:0];
   assign f_mode = (f_sa == '0) || (f_sa == '1);

   rt_term_addr #(.TA_W(TA_W), .ODD_PAR(ODD_PAR)) u_ta (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (term_pins),
      .cmd_addr (f_ta),
      .id       (term_id),
      .match    (ta_match)
   );

   // state
   rt_state_e       st_q, dec_state;
   msg_kind_e       kind_q, dec_kind;
   logic [SA_W-1:0] sa_q;
   logic [WC_W-1:0] last_q, idx_q, dec_last;
   logic            svc_q;
   logic            cmd_ok, load;

   assign cmd_ok = rx_edge && rx_cmd && !rx_err && ta_match;
   assign load   = cmd_ok && (st_q == ST_IDLE || st_q == ST_RX);

   always_comb begin
      dec_state = ST_IDLE;
      dec_kind  = MK_RX;
      dec_last  = f_wc - WC_W'(1);
      if (f_mode) begin
         dec_last = '0;
         if (f_tr && f_wc == WC_W'(VEC_MC)) begin
            dec_state = ST_STAT;
            dec_kind  = MK_VEC;
         end else if (!f_tr && f_wc == WC_W'(SYNC_MC)) begin
            dec_state = ST_RX;
            dec_kind  = MK_SYNC;
         end
      end else if (f_tr) begin
         dec_state = ST_STAT;
         dec_kind  = MK_TX;
      end else begin
         dec_state = ST_RX;
         dec_kind  = MK_RX;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= MK_RX;
         sa_q   <= '0;
         last_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         st_q   <= dec_state;
         kind_q <= dec_kind;
         sa_q   <= f_sa;
         last_q <= dec_last;
         idx_q  <= '0;
      end else begin
         case (st_q)
            ST_RX: begin
               if (rx_edge) begin
                  if (rx_err || rx_cmd)    st_q  <= ST_IDLE;
                  else if (idx_q == last_q) st_q <= ST_STAT;
                  else                     idx_q <= idx_q + WC_W'(1);
               end
            end
            ST_STAT: begin
               idx_q <= '0;
               case (kind_q)
                  MK_TX:   st_q <= ST_TXD;
                  MK_VEC:  st_q <= ST_VEC;
                  default: st_q <= ST_IDLE;
               endcase
            end
            ST_TXD: begin
               if (idx_q == last_q) st_q  <= ST_IDLE;
               else                 idx_q <= idx_q + WC_W'(1);
            end
            ST_VEC:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               svc_q <= 1'b0;
      else if (svc_edge)        svc_q <= 1'b1;
      else if (st_q == ST_VEC)  svc_q <= 1'b0;
   end

   // response words
   logic [WORD_W-1:0] status_w;
   always_comb begin
      status_w = '0;
      status_w[WORD_W-1 -: TA_W] = term_id[TA_W-1:0];
      status_w[SVC_BIT] = svc_q;
   end

   assign tx_valid = (st_q == ST_STAT) || (st_q == ST_TXD) || (st_q == ST_VEC);

   always_comb begin
      case (st_q)
         ST_STAT: tx_word = status_w;
         ST_TXD:  tx_word = ram_rdata;
         ST_VEC:  tx_word = {{(WORD_W-1){1'b0}}, svc_q};
         default: tx_word = '0;
      endcase
   end

   // RAM path selection
   logic          wr_en;
   logic [AW-1:0] rd_addr;

   assign wr_en   = (st_q == ST_RX) && rx_edge && !rx_err && !rx_cmd && (kind_q == MK_RX);
   assign rd_addr = (st_q == ST_TXD) ? {sa_q, idx_q + WC_W'(1)} : {sa_q, {WC_W{1'b0}}};

   rt_ram_mux #(.AW(AW), .DW(WORD_W)) u_mux (
      .wr_en     (wr_en),
      .wr_addr   ({sa_q, idx_q}),
      .wr_data   (rx_word),
      .rd_addr   (rd_addr),
      .ram_addr  (ram_addr),
      .ram_we    (ram_we),
      .ram_wdata (ram_wdata)
   );

   // R6
   rx_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RX) |-> (idx_q <= last_q));
   // R9
   svc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_VEC && !svc_edge) |=> !svc_q);
   // R8
   vec_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STAT && kind_q == MK_VEC) |=> (st_q == ST_VEC));
   // R2
   stat_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STAT) |-> (tx_word[WORD_W-1 -: TA_W] == term_id[TA_W-1:0]));
   // R5
   err_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && rx_edge) |-> !ram_we);
endmodule

// File: tb/sim_rt_msg_proc.sv
module sim_rt_msg_proc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  term_pins = '0;
   logic [15:0] rx_word = '0;
   logic        rx_cmd = 1'b0, rx_err = 1'b0, rx_stb = 1'b0, svc_req = 1'b0;
   logic [15:0] ram_rdata;
   logic [5:0]  term_id;
   logic [15:0] tx_word;
   logic        tx_valid;
   logic [9:0]  ram_addr;
   logic        ram_we;
   logic [15:0] ram_wdata;

   int nchk = 0, nerr = 0;
   int txn = 0, wrn = 0;
   logic [15:0] txq [0:255];
   logic [15:0] mem [0:1023];
   logic [15:0] exp_mem [0:1023];

   always #5 clk = ~clk;

   rt_msg_proc u0 (
      .clk(clk), .rst_n(rst_n), .term_pins(term_pins), .rx_word(rx_word),
      .rx_cmd(rx_cmd), .rx_err(rx_err), .rx_stb(rx_stb), .svc_req(svc_req),
      .ram_rdata(ram_rdata), .term_id(term_id), .tx_word(tx_word),
      .tx_valid(tx_valid), .ram_addr(ram_addr), .ram_we(ram_we),
      .ram_wdata(ram_wdata)
   );

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 40503) ^ 16'h5A5A);
   endfunction

   function automatic logic [15:0] cmdw(input int ta, input int tr, input int sa, input int wc);
      return 16'((ta % 32) * 2048 + (tr % 2) * 1024 + (sa % 32) * 32 + (wc % 32));
   endfunction

   function automatic logic [15:0] stat(input int svc);
      return 16'(5 * 2048 + svc * 256);
   endfunction

   // RAM model driven only through the block's RAM port
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      end else if (ram_we) begin
         mem[ram_addr] <= ram_wdata;
      end
      ram_rdata <= mem[ram_addr];
   end

   always @(negedge clk) begin
      if (tx_valid) begin
         txq[txn % 256] <= tx_word;
         txn <= txn + 1;
      end
      if (ram_we) wrn <= wrn + 1;
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic send_word(input logic [15:0] w, input logic c, input logic e);
      @(negedge clk);
      rx_word = w; rx_cmd = c; rx_err = e; rx_stb = 1'b1;
      repeat (3) @(negedge clk);
      rx_stb = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic settle();
      repeat (45) @(negedge clk);
   endtask

   task automatic pulse_svc();
      @(negedge clk); svc_req = 1'b1;
      repeat (3) @(negedge clk); svc_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_tx(input int sa, input int wc, input string rq);
      int n, bt;
      n = (wc == 0) ? 32 : wc;
      bt = txn;
      send_word(cmdw(5, 1, sa, wc), 1'b1, 1'b0);
      settle();
      chk(txn - bt == n + 1, rq, txn - bt, n + 1);
      chk(txq[bt % 256] == stat(0), rq, txq[bt % 256], stat(0));
      for (int i = 0; i < n; i++)
         chk(txq[(bt + 1 + i) % 256] == exp_mem[sa * 32 + i], rq,
             txq[(bt + 1 + i) % 256], exp_mem[sa * 32 + i]);
   endtask

   task automatic do_vec(input int sa, input int svc, input string rq);
      int bt;
      bt = txn;
      send_word(cmdw(5, 1, sa, 16), 1'b1, 1'b0);
      settle();
      chk(txn - bt == 2, rq, txn - bt, 2);
      chk(txq[bt % 256] == stat(svc), rq, txq[bt % 256], stat(svc));
      chk(txq[(bt + 1) % 256] == 16'(svc), rq, txq[(bt + 1) % 256], svc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int bt, bw, n;
      logic [15:0] d;
      for (int i = 0; i < 1024; i++) exp_mem[i] = pat(i);
      repeat (4) @(negedge clk);
      // R2 reset state
      chk(tx_valid == 1'b0, "R2 reset tx_valid", tx_valid, 0);
      chk(ram_we == 1'b0, "R2 reset ram_we", ram_we, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 every strap value
      for (int p = 0; p < 32; p++) begin
         term_pins = 5'(p);
         repeat (2) @(negedge clk);
         chk(term_id == {~^5'(p), 5'(p)}, "R1 parity", term_id, {~^5'(p), 5'(p)});
      end
      term_pins = 5'd5;
      repeat (2) @(negedge clk);

      // R8 vector without request; R2 status layout
      do_vec(0, 0, "R8 vector idle");
      // R9 request set, shown, then cleared
      pulse_svc();
      do_vec(0, 1, "R9 vector requested");
      do_vec(31, 0, "R9 cleared after vector");

      // R3 latency and single action on a held strobe
      bt = txn;
      @(negedge clk);
      rx_word = cmdw(5, 1, 8, 2); rx_cmd = 1'b1; rx_err = 1'b0; rx_stb = 1'b1;
      @(negedge clk);
      chk(tx_valid == 1'b0, "R3 latency early", tx_valid, 0);
      @(negedge clk);
      chk(tx_valid == 1'b1 && tx_word == stat(0), "R3 latency", tx_word, stat(0));
      repeat (6) @(negedge clk);
      rx_stb = 1'b0;
      settle();
      chk(txn - bt == 3, "R3 single response", txn - bt, 3);

      // R7 every word count
      for (int wc = 0; wc < 32; wc++) do_tx(4 + (wc % 24), wc, "R7 transmit sweep");

      // R6 receive then read back
      for (int k = 0; k < 4; k++) begin
         int wc;
         wc = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 0;
         n = (wc == 0) ? 32 : wc;
         bt = txn; bw = wrn;
         send_word(cmdw(5, 0, 1, wc), 1'b1, 1'b0);
         for (int i = 0; i < n; i++) begin
            d = 16'(wc * 4099 + i * 257 + 16'h1111);
            exp_mem[32 + i] = d;
            send_word(d, 1'b0, 1'b0);
         end
         settle();
         chk(txn - bt == 1, "R6 one status", txn - bt, 1);
         chk(txq[bt % 256] == stat(0), "R6 status word", txq[bt % 256], stat(0));
         chk(wrn - bw == n, "R6 write count", wrn - bw, n);
         for (int i = 0; i < n; i++)
            chk(mem[32 + i] == exp_mem[32 + i], "R6 stored word", mem[32 + i], exp_mem[32 + i]);
         do_tx(1, wc, "R6 R7 read back");
      end

      // R4 other address
      bt = txn; bw = wrn;
      send_word(cmdw(6, 1, 8, 3), 1'b1, 1'b0);
      send_word(cmdw(4, 0, 2, 1), 1'b1, 1'b0);
      send_word(16'hBEEF, 1'b0, 1'b0);
      settle();
      chk(txn - bt == 0, "R4 no response", txn - bt, 0);
      chk(wrn - bw == 0, "R4 no write", wrn - bw, 0);

      // R5 flagged command, then flagged data inside a receive
      bt = txn; bw = wrn;
      send_word(cmdw(5, 1, 8, 3), 1'b1, 1'b1);
      settle();
      chk(txn - bt == 0, "R5 flagged command", txn - bt, 0);
      bt = txn;
      send_word(cmdw(5, 0, 2, 2), 1'b1, 1'b0);
      send_word(16'h1234, 1'b0, 1'b0);
      exp_mem[64] = 16'h1234;
      send_word(16'h5678, 1'b0, 1'b1);
      settle();
      chk(txn - bt == 0, "R5 aborted no status", txn - bt, 0);
      chk(wrn - bw == 1, "R5 one write only", wrn - bw, 1);
      chk(mem[65] == exp_mem[65], "R5 flagged word not stored", mem[65], exp_mem[65]);

      // R11 receive cut short by a new command
      bt = txn; bw = wrn;
      send_word(cmdw(5, 0, 3, 3), 1'b1, 1'b0);
      send_word(16'hA001, 1'b0, 1'b0);
      exp_mem[96] = 16'hA001;
      send_word(cmdw(5, 1, 9, 1), 1'b1, 1'b0);
      settle();
      chk(wrn - bw == 1, "R11 write count", wrn - bw, 1);
      chk(txn - bt == 2, "R11 only new message", txn - bt, 2);
      chk(txq[(bt + 1) % 256] == exp_mem[9 * 32], "R11 new data", txq[(bt + 1) % 256], exp_mem[9 * 32]);

      // R10 synchronize with data word, both mode subaddresses
      for (int s = 0; s < 2; s++) begin
         bt = txn; bw = wrn;
         send_word(cmdw(5, 0, s * 31, 17), 1'b1, 1'b0);
         send_word(16'h0F0F, 1'b0, 1'b0);
         settle();
         chk(txn - bt == 1, "R10 status only", txn - bt, 1);
         chk(txq[bt % 256] == stat(0), "R10 status", txq[bt % 256], stat(0));
         chk(wrn - bw == 0, "R10 no write", wrn - bw, 0);
      end

      // R12 unsupported mode codes and wrong directions
      bt = txn;
      send_word(cmdw(5, 1, 0, 2), 1'b1, 1'b0);
      send_word(cmdw(5, 0, 31, 16), 1'b1, 1'b0);
      send_word(cmdw(5, 1, 0, 17), 1'b1, 1'b0);
      settle();
      chk(txn - bt == 0, "R12 no response", txn - bt, 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule